// File: doc/BRIEF.md
# Spike-Coded Frame Difference Motion Detector

This block finds motion at a single pixel whose luminance arrives as a rate-coded spike train. Time advances in ticks, marked by a one-cycle `tick` strobe. Every 33 ticks form one frame, and the pixel value for that frame is the number of spikes (0 to 15) that arrive in the frame's first 15 ticks.

The block compares each frame with the frame that came k frames earlier. It keeps that older frame as a spike count and replays it as a burst. Two signed accumulators build up the two signs of the difference. At a fixed probe tick the accumulators are tested against a threshold, and after that test they are cleared. Detection is held off until the first delayed frame exists.

Detections feed a leaky history potential. On every tick that potential is compared with a pseudo-random level, so it fires often just after motion and less and less as it leaks away. This leaves a fading tail. The fires within a frame are counted, and one output pulse per frame reports whether the count reached a programmable minimum. Each instance covers one pixel, and a pixel array uses one instance per pixel.

Top module: `spike_motion_detector`

## Requirements
- R1: Tick positions run 0 to 32 and wrap back to 0. The first `tick` after reset is position 0. Only spikes presented with `tick` at positions 0 to 14 count toward a frame, and spikes at positions 15 to 32 have no effect.
- R2: The reference frame is the one k frames back, where k is `cfg_k`. A `cfg_k` of 0 acts as 1, and values above K_MAX (default 4) act as K_MAX. The reference count is replayed as spikes at positions 0 to count-1.
- R3: At position 16 a detection occurs when |current count − reference count| ≥ `cfg_thresh`. There is at most one detection per frame.
- R4: Both difference accumulators are cleared on the position-17 tick, so each frame's decision depends only on that frame and its reference.
- R5: For k_eff as defined in R2, no detection occurs in frames 0 to k_eff−1 after reset.
- R6: On every tick the history potential becomes clamp(v + 128·detection − `cfg_leak`, 0, 255). It stays unchanged between ticks.
- R7: On a tick, the history stage fires when the new potential is greater than the low 8 bits of a 16-bit LFSR. The LFSR then steps once to {s[14:0], s15^s13^s12^s10}, with the feedback polynomial x^16+x^14+x^13+x^11+1. At reset the LFSR is loaded from `cfg_seed`, and a seed of 0 is replaced by 16'hACE1.
- R8: `spike_out` is high for exactly one clock, in the cycle after the position-32 tick, and only if the number of fires in that frame (positions 0 to 32) is ≥ `cfg_bin`. It is low at all other times.
- R9: While `rst_n` is low, `spike_out` is 0, and the potential, accumulators, stored frames and tick position return to zero. Reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle tick strobe |
| spike_in | input | 1 | Input spike, sampled with `tick` |
| cfg_k | input | 3 | Frame separation k |
| cfg_thresh | input | 4 | Difference threshold |
| cfg_leak | input | 8 | History leak per tick |
| cfg_bin | input | 6 | Minimum fires per frame for an output pulse |
| cfg_seed | input | 16 | LFSR seed, loaded during reset |
| spike_out | output | 1 | Binarized motion pulse, at most one per frame |

## Verification
The bench places spikes after the counting window. A design that counts them would report motion on frames whose counted spikes are identical. Alternating full and empty frames at k=3 check both the suppression window and the k-frame offset: an off-by-one read from the frame store would shift the first detection or make detection stop altogether. A threshold of zero, k values of 0 and 7, and a zero seed cover the clamping and fallback rules. Random frames run against a tick-exact model of the leak, the clamping and the LFSR. That model exposes a stale accumulator, a wrong clamp or a fire count that misses the last tick of the frame.

// File: rtl/mdet_pkg.sv
package mdet_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_FALLBACK = 16'hACE1;

    // One step of the history noise source (x^16+x^14+x^13+x^11+1).
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/mdet_frame_timer.sv
module mdet_frame_timer #(
    parameter int FRAME_TICKS = 33,
    parameter int K_MAX       = 4,
    localparam int PW = $clog2(FRAME_TICKS),
    localparam int KW = $clog2(K_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [PW-1:0] pos,
    output logic          frame_end,
    output logic [KW-1:0] frames_done
);
    localparam logic [PW-1:0] LAST_P = PW'(FRAME_TICKS - 1);
    localparam logic [KW-1:0] KSAT   = KW'(K_MAX);

    typedef struct packed {
        logic [PW-1:0] pos;
        logic [KW-1:0] seen;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.pos == LAST_P) begin
                st_d.pos = '0;
                if (st_q.seen != KSAT) st_d.seen = st_q.seen + 1'b1;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos         = st_q.pos;
    assign frames_done = st_q.seen;
    assign frame_end   = tick && (st_q.pos == LAST_P);

    // R1
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= LAST_P);

    // R1
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.pos));

endmodule

// File: rtl/mdet_diff_core.sv
module mdet_diff_core #(
    parameter int FRAME_TICKS = 33,
    parameter int WINDOW      = 15,
    parameter int PROBE_AT    = 16,
    parameter int K_MAX       = 4,
    parameter int CNT_W       = 4,
    localparam int PW = $clog2(FRAME_TICKS),
    localparam int KW = $clog2(K_MAX + 1),
    localparam int SW = $clog2(K_MAX),
    localparam int AW = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             spike_in,
    input  logic [PW-1:0]    pos,
    input  logic [KW-1:0]    frames_done,
    input  logic [KW-1:0]    cfg_k,
    input  logic [CNT_W-1:0] cfg_thresh,
    output logic             det
);
    localparam logic [PW-1:0] WIN_P   = PW'(WINDOW);
    localparam logic [PW-1:0] PROBE_P = PW'(PROBE_AT);
    localparam logic [PW-1:0] CLEAR_P = PW'(PROBE_AT + 1);
    localparam logic [PW-1:0] LAST_P  = PW'(FRAME_TICKS - 1);
    localparam logic [KW-1:0] KSAT    = KW'(K_MAX);
    localparam logic [SW-1:0] SLOT_LAST = SW'(K_MAX - 1);
    localparam logic signed [AW-1:0] WIN_S = AW'(WINDOW);

    typedef struct packed {
        logic [K_MAX-1:0][CNT_W-1:0] ring;
        logic [SW-1:0]               slot;
        logic [CNT_W-1:0]            cnt;
        logic signed [AW-1:0]        acc_p;
        logic signed [AW-1:0]        acc_n;
    } diff_t;

    diff_t st_d, st_q;

    logic [KW-1:0]        k_eff;
    logic [SW-1:0]        rd_idx;
    logic [CNT_W-1:0]     dly;
    logic                 in_win, cur_sp, del_sp;
    logic signed [AW-1:0] step, th_s;

    always_comb begin
        int r;
        if (cfg_k == '0)       k_eff = KW'(1);
        else if (cfg_k > KSAT) k_eff = KSAT;
        else                   k_eff = cfg_k;

        r = int'(st_q.slot) - int'(k_eff);
        if (r < 0) r = r + K_MAX;
        rd_idx = SW'(r);
        dly    = st_q.ring[rd_idx];

        in_win = pos < WIN_P;
        cur_sp = tick && spike_in && in_win;
        del_sp = tick && in_win && (pos < PW'(dly));

        step = '0;
        if (cur_sp && !del_sp)      step = AW'(1);
        else if (del_sp && !cur_sp) step = '1;

        th_s = $signed({1'b0, cfg_thresh});
        det  = tick && (pos == PROBE_P) && (frames_done >= k_eff)
               && ((st_q.acc_p >= th_s) || (st_q.acc_n >= th_s));

        st_d = st_q;
        if (tick) begin
            if (pos == CLEAR_P) begin
                st_d.acc_p = '0;
                st_d.acc_n = '0;
            end else begin
                st_d.acc_p = st_q.acc_p + step;
                st_d.acc_n = st_q.acc_n - step;
            end
            if (cur_sp) st_d.cnt = st_q.cnt + 1'b1;
            if (pos == LAST_P) begin
                st_d.ring[st_q.slot] = st_q.cnt;
                st_d.cnt  = '0;
                st_d.slot = (st_q.slot == SLOT_LAST) ? '0 : st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pos == CLEAR_P) |=> (st_q.acc_p == 0 && st_q.acc_n == 0));

    // R1
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc_p <= WIN_S) && (st_q.acc_p >= -WIN_S)
        && (st_q.acc_n <= WIN_S) && (st_q.acc_n >= -WIN_S));

    // R1
    late_spike_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pos >= WIN_P && pos != LAST_P) |=> $stable(st_q.cnt));

    // R5
    first_frame_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frames_done == '0) |-> !det);

endmodule

// File: rtl/mdet_history.sv
module mdet_history #(
    parameter int HIST_W      = 8,
    parameter int HIST_WEIGHT = 128,
    parameter int FCNT_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              det,
    input  logic              frame_end,
    input  logic [HIST_W-1:0] cfg_leak,
    input  logic [FCNT_W-1:0] cfg_bin,
    input  logic [15:0]       cfg_seed,
    output logic              spike_out
);
    import mdet_pkg::*;

    localparam int EW = HIST_W + 2;
    localparam logic [EW-1:0] W_EXT = EW'(HIST_WEIGHT);
    localparam logic [EW-1:0] V_MAX = EW'((1 << HIST_W) - 1);

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
        logic [HIST_W-1:0] v;
        logic [FCNT_W-1:0] fcnt;
        logic              out;
    } hist_t;

    hist_t st_d, st_q;

    logic [EW-1:0]     up, leak_ext, lim;
    logic [HIST_W-1:0] v_new;
    logic              fire;
    logic [FCNT_W-1:0] fcnt_tot;

    always_comb begin
        leak_ext = {2'b00, cfg_leak};
        up       = {2'b00, st_q.v} + (det ? W_EXT : '0);
        if (up <= leak_ext) lim = '0;
        else                lim = up - leak_ext;
        if (lim > V_MAX) lim = V_MAX;
        v_new    = lim[HIST_W-1:0];
        fire     = v_new > st_q.lfsr[HIST_W-1:0];
        fcnt_tot = st_q.fcnt + FCNT_W'(fire);

        st_d     = st_q;
        st_d.out = 1'b0;
        if (tick) begin
            st_d.v    = v_new;
            st_d.lfsr = lfsr_step(st_q.lfsr);
            st_d.fcnt = fcnt_tot;
            if (frame_end) begin
                st_d.out  = fcnt_tot >= cfg_bin;
                st_d.fcnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lfsr <= (cfg_seed == '0) ? LFSR_FALLBACK : cfg_seed;
        end else begin
            st_q <= st_d;
        end
    end

    assign spike_out = st_q.out;

    // R6
    pot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.v));

    // R7
    lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != '0);

    // R6
    leak_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !det) |=> (st_q.v <= $past(st_q.v)));

endmodule

// File: rtl/spike_motion_detector.sv
module spike_motion_detector #(
    parameter int FRAME_TICKS = 33,
    parameter int WINDOW      = 15,
    parameter int PROBE_AT    = 16,
    parameter int K_MAX       = 4,
    parameter int CNT_W       = 4,
    parameter int HIST_W      = 8,
    parameter int HIST_WEIGHT = 128,
    localparam int KW = $clog2(K_MAX + 1),
    localparam int FCNT_W = $clog2(FRAME_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              spike_in,
    input  logic [KW-1:0]     cfg_k,
    input  logic [CNT_W-1:0]  cfg_thresh,
    input  logic [HIST_W-1:0] cfg_leak,
    input  logic [FCNT_W-1:0] cfg_bin,
    input  logic [15:0]       cfg_seed,
    output logic              spike_out
);
    localparam int PW = $clog2(FRAME_TICKS);
    localparam logic [PW-1:0] LAST_P = PW'(FRAME_TICKS - 1);

    logic [PW-1:0] pos;
    logic          frame_end;
    logic [KW-1:0] frames_done;
    logic          det;

    mdet_frame_timer #(.FRAME_TICKS(FRAME_TICKS), .K_MAX(K_MAX)) i_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .pos(pos), .frame_end(frame_end), .frames_done(frames_done)
    );

    mdet_diff_core #(
        .FRAME_TICKS(FRAME_TICKS), .WINDOW(WINDOW), .PROBE_AT(PROBE_AT),
        .K_MAX(K_MAX), .CNT_W(CNT_W)
    ) i_diff (
        .clk(clk), .rst_n(rst_n), .tick(tick), .spike_in(spike_in),
        .pos(pos), .frames_done(frames_done), .cfg_k(cfg_k),
        .cfg_thresh(cfg_thresh), .det(det)
    );

    mdet_history #(.HIST_W(HIST_W), .HIST_WEIGHT(HIST_WEIGHT), .FCNT_W(FCNT_W)) i_hist (
        .clk(clk), .rst_n(rst_n), .tick(tick), .det(det), .frame_end(frame_end),
        .cfg_leak(cfg_leak), .cfg_bin(cfg_bin), .cfg_seed(cfg_seed),
        .spike_out(spike_out)
    );

    // R8
    out_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spike_out |-> $past(tick && pos == LAST_P));

    // R8
    out_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spike_out |=> !spike_out);

endmodule

// File: tb/test_spike_motion_detector.sv
module test_spike_motion_detector;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       spike_in = 1'b0;
    logic [2:0] cfg_k = 3'd1;
    logic [3:0] cfg_thresh = 4'd0;
    logic [7:0] cfg_leak = 8'd0;
    logic [5:0] cfg_bin = 6'd0;
    logic [15:0] cfg_seed = 16'd1;
    logic       spike_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    spike_motion_detector i_spike_motion_detector (
        .clk(clk), .rst_n(rst_n), .tick(tick), .spike_in(spike_in),
        .cfg_k(cfg_k), .cfg_thresh(cfg_thresh), .cfg_leak(cfg_leak),
        .cfg_bin(cfg_bin), .cfg_seed(cfg_seed), .spike_out(spike_out)
    );

    function automatic logic [15:0] ref_lfsr(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic int ref_keff(input int k);
        if (k == 0) return 1;
        if (k > 4) return 4;
        return k;
    endfunction

    function automatic int ref_pot(input int v, input bit d, input int leak);
        int x;
        x = v + (d ? 128 : 0) - leak;
        if (x < 0) x = 0;
        if (x > 255) x = 255;
        return x;
    endfunction

    task automatic check(input bit act, input bit exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: spike_out=%0b expected %0b at t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_cfg(input int k, input int th, input int leak, input int bin,
                           input int seed, input int nfr, input int mode, input string tag);
        int hist[64];
        int v, fc, cnt, keff, dly;
        logic [15:0] lf;
        bit exp, det;
        logic [14:0] mask;
        cfg_k = 3'(k); cfg_thresh = 4'(th); cfg_leak = 8'(leak);
        cfg_bin = 6'(bin); cfg_seed = 16'(seed);
        @(negedge clk); rst_n = 1'b0; tick = 1'b0; spike_in = 1'b0;
        repeat (3) @(posedge clk);
        #1 check(spike_out, 1'b0, "R9 reset");
        @(negedge clk); rst_n = 1'b1;
        lf = (seed == 0) ? 16'hACE1 : 16'(seed);
        v = 0; fc = 0; keff = ref_keff(k);
        for (int f = 0; f < nfr; f++) begin
            case (mode)
                0: mask = 15'($urandom);
                1: mask = 15'h007F;
                2: mask = f[0] ? 15'h7FFF : 15'h0000;
                default: mask = 15'h0000;
            endcase
            cnt = 0;
            for (int p = 0; p < 15; p++) cnt += int'(mask[p]);
            dly = (f >= keff) ? hist[f - keff] : 0;
            for (int p = 0; p < 33; p++) begin
                bit s;
                if (p < 15) s = mask[p];
                else if (mode == 0) s = ($urandom % 3) == 0;
                else if (mode == 3) s = 1'b1;
                else s = 1'b0;
                det = (p == 16) && (f >= keff)
                      && ((cnt - dly >= th) || (dly - cnt >= th));
                v = ref_pot(v, det, leak);
                if (v > int'(lf[7:0])) fc++;
                lf = ref_lfsr(lf);
                exp = 1'b0;
                if (p == 32) begin
                    exp = fc >= bin;
                    fc = 0;
                end
                @(negedge clk); tick = 1'b1; spike_in = s;
                @(posedge clk); #1;
                if (p == 32) check(spike_out, exp, tag);
                else         check(spike_out, 1'b0, "R8 idle");
                @(negedge clk); tick = 1'b0; spike_in = 1'b0;
            end
            hist[f] = cnt;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (2) @(posedge clk);
        // R3 R4: random frames, k=1
        run_cfg(1, 4, 8, 1, 1234, 14, 0, "R3,R4");
        // R5 R2: alternating full/empty, k=3, detections from frame 3
        run_cfg(3, 15, 0, 1, 77, 12, 2, "R5,R2");
        // R3: equal counts every frame never detect
        run_cfg(2, 1, 0, 1, 991, 8, 1, "R3 equal");
        // R2 R8: k=0 acts as 1, threshold 0, bin 0 always pulses
        run_cfg(0, 0, 200, 0, 4321, 6, 0, "R2,R8");
        // R7: zero seed fallback
        run_cfg(4, 2, 20, 3, 0, 12, 0, "R7 seed0");
        // R2: k=7 clamps to 4
        run_cfg(7, 3, 5, 2, 555, 12, 0, "R2 clamp");
        // R1: spikes only after the counting window
        run_cfg(1, 1, 0, 1, 300, 6, 3, "R1 ignore");
        for (int i = 0; i < 6; i++)
            run_cfg($urandom % 6, $urandom % 16, $urandom % 64, $urandom % 4,
                    $urandom % 65536, 10, 0, "R6,R7,R8 random");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule